// File: doc/BRIEF.md
# Monitor-Wait Idle State Controller

This block sits beside an instruction pipeline and services its requests to wait for an event. For each request it decides whether waiting is allowed at the current privilege level and picks a processor idle state (C-state) and sub-state from a hint word. It then steps through a programmable entry delay, sits resident in the chosen state, and leaves it when an interrupt or a store into the monitored address range says it should. Leaving runs through a programmable exit delay. The block marks the moment of wake-up with a timestamp-capture strobe and then hands control to interrupt service.

The caller supplies the hint word, the privilege level, a user-level-wait enable, a break-on-masked-interrupt bit from the extensions word together with the matching capability enable, and a table of supported sub-states for each state. The monitored range comes in as a base and a mask, and the per-state entry and exit delays come in as packed tables. Power gating, cache handling and the monitor arming logic stay outside the block.

Top module: `idle_state_ctrl`

## Requirements
- R1: The resolved state is never deeper than the hint's state, and the resolved sub-state is never above the hint's sub-state. The hint is 8 bits: bits [7:4] hold the state number minus one and bits [3:0] hold the sub-state. A state field beyond the last implemented state is clamped to the deepest implemented state.
- R2: When `cpl_i` is nonzero and `user_wait_en_i` is 1, a request always resolves to C1 sub-state 0, whatever the hint says.
- R3: When `cpl_i` is nonzero and `user_wait_en_i` is 0, a request pulses `wait_exc_o` for one cycle, one cycle after the request, and the controller stays in RUN.
- R4: If the break bit `ext_brk_i` and the capability `brk_cap_i` were both 1 at the request, a pending interrupt wakes the core while `irq_enable_i` is 0. Without both, a masked interrupt does not wake the core.
- R5: A store wakes the core only if the resolved state is C2 or deeper, the store comes from another processor agent (`store_from_cpu_i`=1), and `(addr ^ base) & mask` is zero. Any other store is ignored.
- R6: Entry lasts entry_latency+1 cycles in ENTER and exit lasts exit_latency+1 cycles in EXIT. Each latency is LAT_W bits, taken at offset (state-1)*LAT_W of its table.
- R7: `ts_capture_o` pulses in the first EXIT cycle. `isr_handoff_o` pulses in the first RUN cycle after EXIT, only after an interrupt wake, and never in the same cycle as the capture pulse.
- R8: If the requested sub-state is not supported (the bit at (state-1)*16+sub of `sub_sup_i` is 0), the controller uses the deepest supported sub-state of that state that lies below the request. If there is none, it uses C1 sub-state 0.
- R9: Requests made outside RUN are ignored, and the resolved state and sub-state stay unchanged.
- R10: With `irq_enable_i`=1, a pending interrupt wakes the core from any idle state, including C1.
- R11: `state_o` encodes RUN=0, ENTER=1, IDLE=2, EXIT=3. `resident_o` is 1 only in IDLE. `cstate_o` gives the state number (0 in RUN) and `csub_o` gives the sub-state (0 in RUN). After reset the controller is in RUN with every pulse low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wait_req_i | input | 1 | Wait request from the pipeline |
| hint_i | input | 2*SW | Requested state minus one [7:4] and sub-state [3:0] |
| ext_brk_i | input | 1 | Extensions word bit 0: break on masked interrupt |
| brk_cap_i | input | 1 | Capability enable for break on masked interrupt |
| cpl_i | input | 2 | Current privilege level |
| user_wait_en_i | input | 1 | Waiting allowed above privilege 0 |
| sub_sup_i | input | NSTATES*16 | Supported sub-state bits for each state |
| ent_lat_i | input | NSTATES*LAT_W | Entry latency for each state |
| ext_lat_i | input | NSTATES*LAT_W | Exit latency for each state |
| irq_pending_i | input | 1 | Interrupt pending |
| irq_enable_i | input | 1 | Interrupts globally enabled |
| store_valid_i | input | 1 | Store observed on the bus |
| store_addr_i | input | AW | Store address |
| store_from_cpu_i | input | 1 | Store came from another processor agent |
| mon_base_i | input | AW | Monitored range base |
| mon_mask_i | input | AW | Monitored range mask |
| state_o | output | 2 | Controller phase |
| cstate_o | output | SW | Resolved state number |
| csub_o | output | SW | Resolved sub-state |
| resident_o | output | 1 | Core resident in the idle state |
| wait_exc_o | output | 1 | Wait-not-allowed exception pulse |
| ts_capture_o | output | 1 | Timestamp-capture strobe |
| isr_handoff_o | output | 1 | Interrupt-service handoff pulse |

## Verification
A request seen at one edge shows up one cycle later, as ENTER with the resolved state or as the exception pulse. A wake event seen while IDLE moves the core to EXIT at the next edge, and the capture strobe is already high in that cycle. The handoff pulse appears in the first RUN cycle after the exit delay runs out. The bench keeps a behavioural model that advances at each rising edge from the same inputs, and it compares every output to that model at the falling edge. Directed checks are placed on the exact cycles given above.

// File: rtl/idle_state_ctrl.sv
module idle_state_ctrl #(
  parameter int NSTATES = 4,
  parameter int SW      = 4,
  parameter int LAT_W   = 8,
  parameter int AW      = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wait_req_i,
  input  logic [2*SW-1:0]          hint_i,
  input  logic                     ext_brk_i,
  input  logic                     brk_cap_i,
  input  logic [1:0]               cpl_i,
  input  logic                     user_wait_en_i,
  input  logic [NSTATES*(1<<SW)-1:0] sub_sup_i,
  input  logic [NSTATES*LAT_W-1:0] ent_lat_i,
  input  logic [NSTATES*LAT_W-1:0] ext_lat_i,
  input  logic                     irq_pending_i,
  input  logic                     irq_enable_i,
  input  logic                     store_valid_i,
  input  logic [AW-1:0]            store_addr_i,
  input  logic                     store_from_cpu_i,
  input  logic [AW-1:0]            mon_base_i,
  input  logic [AW-1:0]            mon_mask_i,
  output logic [1:0]               state_o,
  output logic [SW-1:0]            cstate_o,
  output logic [SW-1:0]            csub_o,
  output logic                     resident_o,
  output logic                     wait_exc_o,
  output logic                     ts_capture_o,
  output logic                     isr_handoff_o
);
  localparam int NSUB = 1 << SW;
  localparam logic [SW-1:0] TOP = SW'(NSTATES - 1);

  typedef enum logic [1:0] {RUN = 2'd0, ENTER = 2'd1, IDLE = 2'd2, EXIT = 2'd3} phase_t;

  phase_t           st;
  logic [SW-1:0]    c_idx, c_sub, r_idx, r_sub, h_st, h_sub;
  logic [LAT_W-1:0] cnt;
  logic             brk_ok, irq_wake, exc_q, ts_q, ho_q;
  logic             found, deny, irq_w, sto_w;
  logic [NSUB-1:0]  row;

  assign h_st  = (hint_i[2*SW-1:SW] > TOP) ? TOP : hint_i[2*SW-1:SW];
  assign h_sub = hint_i[SW-1:0];
  assign row   = sub_sup_i[h_st*NSUB +: NSUB];
  assign deny  = (cpl_i != 2'd0) && !user_wait_en_i;

  always_comb begin
    found = 1'b0;
    r_sub = '0;
    for (int i = 0; i < NSUB; i++)
      if (SW'(i) <= h_sub && row[i]) begin
        found = 1'b1;
        r_sub = SW'(i);
      end
    r_idx = h_st;
    if (cpl_i != 2'd0 || !found) begin
      r_idx = '0;
      r_sub = '0;
    end
  end

  assign irq_w = irq_pending_i && (irq_enable_i || brk_ok);
  assign sto_w = store_valid_i && store_from_cpu_i && (c_idx != '0) &&
                 (((store_addr_i ^ mon_base_i) & mon_mask_i) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= RUN;
      c_idx    <= '0;
      c_sub    <= '0;
      cnt      <= '0;
      brk_ok   <= 1'b0;
      irq_wake <= 1'b0;
      exc_q    <= 1'b0;
      ts_q     <= 1'b0;
      ho_q     <= 1'b0;
    end else begin
      exc_q <= 1'b0;
      ts_q  <= 1'b0;
      ho_q  <= 1'b0;
      unique case (st)
        RUN: if (wait_req_i) begin
          if (deny) exc_q <= 1'b1;
          else begin
            st     <= ENTER;
            c_idx  <= r_idx;
            c_sub  <= r_sub;
            cnt    <= ent_lat_i[r_idx*LAT_W +: LAT_W];
            brk_ok <= ext_brk_i && brk_cap_i;
          end
        end
        ENTER: if (cnt == '0) st <= IDLE; else cnt <= cnt - 1'b1;
        IDLE: if (irq_w || sto_w) begin
          st       <= EXIT;
          cnt      <= ext_lat_i[c_idx*LAT_W +: LAT_W];
          ts_q     <= 1'b1;
          irq_wake <= irq_w;
        end
        EXIT: if (cnt == '0) begin
          st   <= RUN;
          ho_q <= irq_wake;
        end else cnt <= cnt - 1'b1;
        default: st <= RUN;
      endcase
    end
  end

  assign state_o       = st;
  assign cstate_o      = (st == RUN) ? '0 : c_idx + 1'b1;
  assign csub_o        = (st == RUN) ? '0 : c_sub;
  assign resident_o    = (st == IDLE);
  assign wait_exc_o    = exc_q;
  assign ts_capture_o  = ts_q;
  assign isr_handoff_o = ho_q;
endmodule

// File: rtl/idle_state_ctrl_chk.sv
module idle_state_ctrl_chk #(
  parameter int SW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wait_req_i,
  input logic [2*SW-1:0] hint_i,
  input logic [1:0]    cpl_i,
  input logic          user_wait_en_i,
  input logic          irq_pending_i,
  input logic          store_valid_i,
  input logic          store_from_cpu_i,
  input logic [1:0]    state_o,
  input logic [SW-1:0] cstate_o,
  input logic [SW-1:0] csub_o,
  input logic          wait_exc_o,
  input logic          ts_capture_o,
  input logic          isr_handoff_o
);
  assert_depth_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd1 && $past(state_o) == 2'd0) |->
      ({1'b0, cstate_o} <= {1'b0, $past(hint_i[2*SW-1:SW])} + (SW+1)'(1)) &&
      (csub_o <= $past(hint_i[SW-1:0])));

  assert_user_c1_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd1 && $past(state_o) == 2'd0 && $past(cpl_i) != 2'd0) |->
      (cstate_o == SW'(1) && csub_o == '0));

  assert_exc_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wait_exc_o |-> ($past(wait_req_i) && $past(cpl_i) != 2'd0 &&
                    !$past(user_wait_en_i) && state_o == 2'd0));

  assert_store_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd3 && $past(state_o) == 2'd2 && !$past(irq_pending_i)) |->
      ($past(store_valid_i) && $past(store_from_cpu_i) && $past(cstate_o) > SW'(1)));

  assert_ts_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ts_capture_o |-> (state_o == 2'd3 && $past(state_o) == 2'd2));

  assert_handoff_after_R7: assert property (@(posedge clk) disable iff (!rst_n)
    isr_handoff_o |-> (!ts_capture_o && state_o == 2'd0 && $past(state_o) == 2'd3));

  assert_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o != 2'd0 && $past(state_o) != 2'd0) |-> ($stable(cstate_o) && $stable(csub_o)));
endmodule

bind idle_state_ctrl idle_state_ctrl_chk #(.SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wait_req_i(wait_req_i), .hint_i(hint_i),
  .cpl_i(cpl_i), .user_wait_en_i(user_wait_en_i), .irq_pending_i(irq_pending_i),
  .store_valid_i(store_valid_i), .store_from_cpu_i(store_from_cpu_i),
  .state_o(state_o), .cstate_o(cstate_o), .csub_o(csub_o), .wait_exc_o(wait_exc_o),
  .ts_capture_o(ts_capture_o), .isr_handoff_o(isr_handoff_o)
);

// File: tb/idle_state_ctrl_tb.sv
module idle_state_ctrl_tb;
  localparam int NS = 4, SW = 4, LW = 8, AW = 32;

  logic clk = 0, rst_n = 0;
  logic wait_req = 0, ext_brk = 0, brk_cap = 0, uen = 0;
  logic [7:0] hint = 0;
  logic [1:0] cpl = 0;
  logic [NS*16-1:0] sub_sup = {16'h0012, 16'h0000, 16'h0005, 16'h0003};
  logic [NS*LW-1:0] ent_lat = {8'd4, 8'd3, 8'd2, 8'd1};
  logic [NS*LW-1:0] ext_lat = {8'd3, 8'd2, 8'd1, 8'd0};
  logic irq_p = 0, irq_en = 0, sv = 0, sfc = 0;
  logic [AW-1:0] saddr = 0;
  logic [AW-1:0] mbase = 32'h0000_1000, mmask = 32'hFFFF_FF00;
  logic [1:0] st_o;
  logic [SW-1:0] cs_o, sub_o;
  logic res_o, exc_o, ts_o, ho_o;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  idle_state_ctrl #(.NSTATES(NS), .SW(SW), .LAT_W(LW), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wait_req_i(wait_req), .hint_i(hint),
    .ext_brk_i(ext_brk), .brk_cap_i(brk_cap), .cpl_i(cpl), .user_wait_en_i(uen),
    .sub_sup_i(sub_sup), .ent_lat_i(ent_lat), .ext_lat_i(ext_lat),
    .irq_pending_i(irq_p), .irq_enable_i(irq_en), .store_valid_i(sv),
    .store_addr_i(saddr), .store_from_cpu_i(sfc), .mon_base_i(mbase), .mon_mask_i(mmask),
    .state_o(st_o), .cstate_o(cs_o), .csub_o(sub_o), .resident_o(res_o),
    .wait_exc_o(exc_o), .ts_capture_o(ts_o), .isr_handoff_o(ho_o));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference: phase, state number (1-based), sub, counter, pulses
  int m_ph = 0, m_cs = 0, m_sub = 0, m_cnt = 0;
  bit m_brk = 0, m_iw = 0, m_exc = 0, m_ts = 0, m_ho = 0;

  function automatic int want_state(input logic [7:0] h, input logic [1:0] c);
    int s = (h[7:4] > NS - 1) ? NS : h[7:4] + 1;
    if (c != 0) return 1;
    for (int k = h[3:0]; k >= 0; k--) if (sub_sup[(s-1)*16 + k]) return s;
    return 1;
  endfunction

  function automatic int want_sub(input logic [7:0] h, input logic [1:0] c);
    int s = (h[7:4] > NS - 1) ? NS : h[7:4] + 1;
    if (c != 0) return 0;
    for (int k = h[3:0]; k >= 0; k--) if (sub_sup[(s-1)*16 + k]) return k;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_cs = 0; m_sub = 0; m_cnt = 0;
      m_brk = 0; m_iw = 0; m_exc = 0; m_ts = 0; m_ho = 0;
    end else begin
      bit iw, sw;
      m_exc = 0; m_ts = 0; m_ho = 0;
      iw = irq_p && (irq_en || m_brk);
      sw = sv && sfc && (m_cs > 1) && (((saddr ^ mbase) & mmask) == 0);
      if (m_ph == 0) begin
        if (wait_req) begin
          if (cpl != 0 && !uen) m_exc = 1;
          else begin
            m_ph = 1; m_cs = want_state(hint, cpl); m_sub = want_sub(hint, cpl);
            m_cnt = int'(ent_lat[(m_cs-1)*LW +: LW]); m_brk = ext_brk && brk_cap;
          end
        end
      end else if (m_ph == 1) begin
        if (m_cnt == 0) m_ph = 2; else m_cnt--;
      end else if (m_ph == 2) begin
        if (iw || sw) begin
          m_ph = 3; m_cnt = int'(ext_lat[(m_cs-1)*LW +: LW]); m_ts = 1; m_iw = iw;
        end
      end else begin
        if (m_cnt == 0) begin m_ph = 0; m_ho = m_iw; end else m_cnt--;
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk(st_o == 2'(m_ph), "R6/R9/R11 phase", st_o, m_ph);
    chk(cs_o == SW'(m_ph == 0 ? 0 : m_cs), "R1/R2/R8 state", cs_o, m_ph == 0 ? 0 : m_cs);
    chk(sub_o == SW'(m_ph == 0 ? 0 : m_sub), "R1/R8 sub", sub_o, m_ph == 0 ? 0 : m_sub);
    chk(res_o == (m_ph == 2), "R11 resident", res_o, m_ph == 2);
    chk(exc_o == m_exc, "R3 exception", exc_o, m_exc);
    chk(ts_o == m_ts, "R7 capture", ts_o, m_ts);
    chk(ho_o == m_ho, "R7 handoff", ho_o, m_ho);
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic req(input logic [7:0] h, input logic [1:0] c, input logic u, input logic e);
    hint = h; cpl = c; uen = u; ext_brk = e; brk_cap = 1; wait_req = 1;
    tick();
    wait_req = 0;
  endtask

  task automatic wait_for(input int ph, output int n);
    n = 0;
    while (st_o != 2'(ph) && n < 100) begin tick(); n++; end
  endtask

  task automatic store(input logic [AW-1:0] a, input logic fromcpu);
    saddr = a; sfc = fromcpu; sv = 1;
    tick();
    sv = 0;
  endtask

  initial begin
    int n;
    repeat (3) tick();
    chk(st_o == 0 && exc_o == 0 && ts_o == 0 && ho_o == 0 && cs_o == 0, "R11 reset", st_o, 0);
    rst_n = 1;
    tick();

    // R1/R8: C2 sub3 unsupported -> C2 sub2; R6 entry length
    req(8'h13, 0, 0, 0);
    n = 0;
    while (st_o == 1 && n < 50) begin n++; tick(); end
    chk(n == 3, "R6 entry cycles", n, 3);
    chk(cs_o == 2 && sub_o == 2, "R8 fallback sub", sub_o, 2);
    irq_en = 1; irq_p = 1;
    wait_for(3, n);
    chk(ts_o == 1, "R7 capture first exit cycle", ts_o, 1);
    wait_for(0, n);
    chk(ho_o == 1, "R7 handoff after irq wake", ho_o, 1);
    irq_p = 0; irq_en = 0;
    tick();

    // R8: C3 has no sub-state -> C1 sub0; R9 request ignored while idle
    req(8'h21, 0, 0, 0);
    wait_for(2, n);
    chk(cs_o == 1 && sub_o == 0, "R8 empty row to C1", cs_o, 1);
    req(8'h37, 0, 0, 0);
    repeat (2) tick();
    chk(cs_o == 1 && st_o == 2, "R9 ignored request", cs_o, 1);
    // R5: store into range at C1 does not wake; R4: masked irq without break bit does not wake
    store(32'h0000_1010, 1);
    irq_p = 1;
    repeat (3) tick();
    chk(st_o == 2, "R5/R4 no wake at C1", st_o, 2);
    irq_en = 1;
    tick(); tick();
    chk(st_o == 3 || st_o == 0, "R10 irq wakes C1", st_o, 3);
    wait_for(0, n);
    irq_p = 0; irq_en = 0;
    tick();

    // R1/R8: C4 sub7 -> C4 sub4; R5 store filters; R6 exit length
    req(8'h37, 0, 0, 0);
    wait_for(2, n);
    chk(cs_o == 4 && sub_o == 4, "R1 C4 sub4", sub_o, 4);
    store(32'h0000_1044, 0);
    tick();
    chk(st_o == 2, "R5 non-processor store ignored", st_o, 2);
    store(32'h0000_2044, 1);
    tick();
    chk(st_o == 2, "R5 store outside range ignored", st_o, 2);
    store(32'h0000_1044, 1);
    chk(st_o == 3 && ts_o == 1, "R5 processor store wakes", st_o, 3);
    n = 0;
    while (st_o == 3 && n < 50) begin n++; tick(); end
    chk(n == 4, "R6 exit cycles", n, 4);
    chk(ho_o == 0, "R7 no handoff after store wake", ho_o, 0);
    tick();

    // R4: break on masked interrupt
    req(8'h10, 0, 0, 1);
    wait_for(2, n);
    chk(cs_o == 2 && sub_o == 0, "R1 C2 sub0", cs_o, 2);
    irq_p = 1;
    tick();
    chk(st_o == 3, "R4 masked irq wakes", st_o, 3);
    wait_for(0, n);
    irq_p = 0;
    tick();

    // R2: user level forced to C1
    req(8'h37, 3, 1, 0);
    chk(st_o == 1 && cs_o == 1 && sub_o == 0, "R2 user C1", cs_o, 1);
    wait_for(2, n);
    irq_en = 1; irq_p = 1;
    wait_for(0, n);
    irq_p = 0; irq_en = 0;
    tick();

    // R3: not allowed at user level
    req(8'h37, 2, 0, 0);
    chk(exc_o == 1 && st_o == 0, "R3 exception", exc_o, 1);
    tick();
    chk(exc_o == 0 && st_o == 0, "R3 single pulse", exc_o, 0);

    // R1: state field beyond implemented states clamps to C4
    req(8'hF2, 0, 0, 0);
    wait_for(2, n);
    chk(cs_o == 4 && sub_o == 1, "R1 clamp state", sub_o, 1);
    irq_en = 1; irq_p = 1;
    wait_for(0, n);
    irq_p = 0; irq_en = 0;
    repeat (3) tick();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule